// File: doc/BRIEF.md
# Coalescing Store Write Buffer

This block sits between a processor's store path and the memory bus. It holds up to eight pending writes. Each entry covers one aligned 16-byte block and carries a 16-bit byte-enable mask. The memory side drains entries one at a time over a ready/valid write port, oldest entry first.

Two inputs decide whether an incoming store may combine with a buffered entry for the same block: a global combine enable and the store's own region attribute. Both must be set. Combining saves bus writes, but it can move a store's bytes ahead of stores that were accepted after the entry was allocated. With combining off, every store becomes its own memory write, in the order the stores were accepted.

Stores tagged as unbuffered (non-cacheable and non-bufferable) are never queued. Such a store waits until the buffer is empty. It then goes straight to the memory port, and it is acknowledged in the same cycle that memory accepts it. A drain input stops new stores from being accepted and reports completion once the buffer is empty.

Top module: `store_merge_buffer`

## Requirements
- R1: After reset the buffer is empty: `mem_valid` is low, `drain_done` is low, and `st_ready` is high for a buffered store when `drain_req` is low.
- R2: While `merge_en` is low, every accepted buffered store produces exactly one memory write. These writes appear in acceptance order.
- R3: A store combines with an entry only when `merge_en` and `st_coal` are both high and `st_sync` is low. Otherwise it allocates a new entry.
- R4: A combining store targets the youngest entry whose block address matches. Each byte with `st_be[i]` set (data bits 8i+7..8i) overwrites that byte of the entry, and `st_be` is ORed into the entry's mask.
- R5: The oldest entry, which is the one offered on the memory port, is never a combine target. A store that matches only that entry allocates a new entry.
- R6: Entries leave in allocation order. Combining into an entry does not change its position.
- R7: When all eight entries are in use, a store that cannot combine sees `st_ready` low. A store that can combine is still accepted.
- R8: A store with `st_sync` high keeps `st_ready` low until the buffer is empty. It is then driven directly on the memory port, and `st_ready` rises in the same cycle as `mem_ready`.
- R9: While `drain_req` is high, `st_ready` is low. `drain_done` is high exactly when `drain_req` is high and the buffer is empty.
- R10: While `mem_valid` is high and `mem_ready` is low for a buffered entry, the memory address, mask and data stay unchanged.
- R11: Address bits 3..0 of a store are ignored. `mem_addr` always has bits 3..0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| merge_en | input | 1 | Global combine enable |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store accepted on this edge |
| st_addr | input | ADDR_W | Store byte address; bits 3..0 ignored |
| st_data | input | 8*LANES | Store data, lane aligned within the block |
| st_be | input | LANES | Store byte enables |
| st_coal | input | 1 | Region allows combining |
| st_sync | input | 1 | Region is non-cacheable and non-bufferable |
| drain_req | input | 1 | Request to empty the buffer |
| drain_done | output | 1 | Drain requested and buffer empty |
| mem_valid | output | 1 | Memory write offered |
| mem_ready | input | 1 | Memory accepts the write |
| mem_addr | output | ADDR_W | Block-aligned write address |
| mem_data | output | 8*LANES | Write data |
| mem_be | output | LANES | Write byte enables |

## Verification
The combine path is exercised with a mixed store sequence. It contains a store to a different block, a store that matches a non-head entry, a store that matches only the head entry, a matching store with its region attribute clear, and two stores whose block appears in more than one entry. Together these separate the head exclusion, the attribute gating and the youngest-match rule. A run with combining off and the buffer full shows strict ordering, and it shows how back-pressure differs between a combining store and a non-combining one. Separate sequences place an unbuffered store and a drain request behind pending entries. They confirm that each one waits for the older writes to leave.

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 8,
  parameter int LANES  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 merge_en,
  input  logic                 st_valid,
  output logic                 st_ready,
  input  logic [ADDR_W-1:0]    st_addr,
  input  logic [8*LANES-1:0]   st_data,
  input  logic [LANES-1:0]     st_be,
  input  logic                 st_coal,
  input  logic                 st_sync,
  input  logic                 drain_req,
  output logic                 drain_done,
  output logic                 mem_valid,
  input  logic                 mem_ready,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [8*LANES-1:0]   mem_data,
  output logic [LANES-1:0]     mem_be
);
  localparam int DW  = 8 * LANES;
  localparam int OFS = $clog2(LANES);
  localparam int TW  = ADDR_W - OFS;
  localparam int PW  = $clog2(DEPTH);
  localparam int CW  = PW + 1;

  logic [TW-1:0]    tag_q [DEPTH];
  logic [DW-1:0]    dat_q [DEPTH];
  logic [LANES-1:0] msk_q [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    cnt_q;

  logic [TW-1:0] st_tag;
  logic          empty, full, hit, mergeable, push, mrg, pop, sync_go;
  logic [PW-1:0] hit_idx, idx;

  assign st_tag = st_addr[ADDR_W-1:OFS];
  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    idx     = '0;
    for (int k = 1; k <= DEPTH; k++) begin
      idx = tail_q - PW'(k);
      if (!hit && CW'(k) <= cnt_q && tag_q[idx] == st_tag) begin
        hit     = 1'b1;
        hit_idx = idx;
      end
    end
  end

  assign mergeable = merge_en && st_coal && !st_sync && hit && (hit_idx != head_q);
  assign st_ready  = !drain_req && (st_sync ? (empty && mem_ready) : (mergeable || !full));
  assign push      = st_valid && st_ready && !st_sync && !mergeable;
  assign mrg       = st_valid && st_ready && mergeable;
  assign pop       = !empty && mem_ready;
  assign sync_go   = st_valid && st_sync && empty && !drain_req;

  assign mem_valid  = !empty || sync_go;
  assign mem_addr   = empty ? {st_tag, {OFS{1'b0}}} : {tag_q[head_q], {OFS{1'b0}}};
  assign mem_data   = empty ? st_data : dat_q[head_q];
  assign mem_be     = empty ? st_be   : msk_q[head_q];
  assign drain_done = drain_req && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop)  head_q <= head_q + PW'(1);
      if (push) tail_q <= tail_q + PW'(1);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      tag_q[tail_q] <= st_tag;
      dat_q[tail_q] <= st_data;
      msk_q[tail_q] <= st_be;
    end
    if (mrg) begin
      for (int b = 0; b < LANES; b++)
        if (st_be[b]) dat_q[hit_idx][8*b +: 8] <= st_data[8*b +: 8];
      msk_q[hit_idx] <= msk_q[hit_idx] | st_be;
    end
  end
endmodule

// File: rtl/store_merge_buffer_chk.sv
module store_merge_buffer_chk #(
  parameter int ADDR_W = 32,
  parameter int LANES  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               st_valid,
  input logic               st_ready,
  input logic               st_sync,
  input logic [LANES-1:0]   st_be,
  input logic               drain_req,
  input logic               drain_done,
  input logic               mem_valid,
  input logic               mem_ready,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [LANES-1:0]   mem_be,
  input logic [8*LANES-1:0] mem_data
);
  localparam int OFS = $clog2(LANES);

  p_drain_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_req |-> !st_ready);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> !mem_valid);

  p_sync_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && st_sync) |-> (mem_valid && mem_ready && mem_be == st_be));

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !st_sync) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_be) && $stable(mem_data)));

  p_addr_align_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[OFS-1:0] == '0));
endmodule

bind store_merge_buffer store_merge_buffer_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (.*);

// File: tb/store_merge_buffer_test.sv
module store_merge_buffer_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int NL = 16;

  localparam int NV = 7;
  localparam logic [31:0] V_ADDR [NV] = '{32'h100, 32'h200, 32'h204, 32'h100, 32'h200, 32'h100, 32'h200};
  localparam logic [15:0] V_BE   [NV] = '{16'h000F, 16'h00F0, 16'h0F00, 16'hF000, 16'h0030, 16'h00F0, 16'h000F};
  localparam logic [7:0]  V_BYTE [NV] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77};
  localparam logic        V_COAL [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1};

  localparam int NE = 4;
  localparam logic [31:0]  E_ADDR [NE] = '{32'h100, 32'h200, 32'h100, 32'h200};
  localparam logic [15:0]  E_BE   [NE] = '{16'h000F, 16'h0FF0, 16'hF0F0, 16'h003F};
  localparam logic [127:0] E_DATA [NE] = '{
    128'h0000_0000_0000_0000_0000_0000_1111_1111,
    128'h0000_0000_3333_3333_2222_2222_0000_0000,
    128'h4444_4444_0000_0000_6666_6666_0000_0000,
    128'h0000_0000_0000_0000_0000_5555_7777_7777};

  logic clk = 0, rst_n = 0;
  logic merge_en = 0, st_valid = 0, st_coal = 0, st_sync = 0, drain_req = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0;
  logic [8*NL-1:0] st_data = '0;
  logic [NL-1:0] st_be = '0;
  logic st_ready, drain_done, mem_valid;
  logic [AW-1:0] mem_addr;
  logic [8*NL-1:0] mem_data;
  logic [NL-1:0] mem_be;

  int nchk = 0, nfail = 0, wcnt = 0, base = 0;
  logic [AW-1:0] w_addr [64];
  logic [8*NL-1:0] w_data [64];
  logic [NL-1:0] w_be [64];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  store_merge_buffer uut (.*);

  always @(posedge clk)
    if (rst_n && mem_valid && mem_ready && wcnt < 64) begin
      w_addr[wcnt] = mem_addr;
      w_data[wcnt] = mem_data;
      w_be[wcnt]   = mem_be;
      wcnt = wcnt + 1;
    end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] masked(input logic [127:0] d, input logic [15:0] m);
    logic [127:0] r = '0;
    for (int b = 0; b < 16; b++) if (m[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic push(input logic [31:0] a, input logic [15:0] be, input logic [7:0] v,
                      input logic c, input logic s);
    @(negedge clk);
    st_valid = 1; st_addr = a; st_be = be; st_data = {16{v}}; st_coal = c; st_sync = s;
    while (!st_ready) @(negedge clk);
    @(negedge clk);
    st_valid = 0; st_sync = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 60 && mem_valid; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mem_valid, "R1 mem_valid", 128'(mem_valid), 0);
    chk(st_ready, "R1 st_ready", 128'(st_ready), 1);
    chk(!drain_done, "R1 drain_done", 128'(drain_done), 0);

    // R3 R4 R5 R6 R11: vector table loaded with memory stalled
    merge_en = 1;
    base = wcnt;
    for (int i = 0; i < NV; i++) push(V_ADDR[i], V_BE[i], V_BYTE[i], V_COAL[i], 1'b0);
    repeat (2) @(negedge clk);
    chk(mem_valid && mem_addr == 32'h100 && mem_be == 16'h000F, "R10 stalled head",
        128'(mem_addr), 128'h100);
    mem_ready = 1;
    wait_idle();
    chk(wcnt - base == NE, "R4 write count", 128'(wcnt - base), NE);
    for (int i = 0; i < NE; i++) begin
      chk(w_addr[base+i] == E_ADDR[i], "R6 R11 addr", 128'(w_addr[base+i]), 128'(E_ADDR[i]));
      chk(w_be[base+i] == E_BE[i], "R4 R5 mask", 128'(w_be[base+i]), 128'(E_BE[i]));
      chk(masked(w_data[base+i], E_BE[i]) == E_DATA[i], "R4 data",
          masked(w_data[base+i], E_BE[i]), E_DATA[i]);
    end

    // R2 R7: fill with combining off, then a matching store
    mem_ready = 0; merge_en = 0; base = wcnt;
    for (int k = 0; k < 8; k++) push(32'h1000 + 32'(16*k), 16'h0001, 8'(k+1), 1'b1, 1'b0);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h1070; st_be = 16'h0002; st_data = {16{8'hAA}}; st_coal = 1;
    repeat (3) @(negedge clk);
    chk(!st_ready, "R7 R3 full holdoff", 128'(st_ready), 0);
    merge_en = 1;
    #1;
    chk(st_ready, "R7 merge when full", 128'(st_ready), 1);
    @(negedge clk);
    st_valid = 0;
    mem_ready = 1;
    wait_idle();
    chk(wcnt - base == 8, "R2 write count", 128'(wcnt - base), 8);
    for (int k = 0; k < 8; k++)
      chk(w_addr[base+k] == 32'h1000 + 32'(16*k), "R2 order", 128'(w_addr[base+k]),
          128'(32'h1000 + 32'(16*k)));
    chk(w_be[base+7] == 16'h0003 && w_data[base+7][15:0] == 16'hAA08, "R4 merged tail",
        128'(w_data[base+7][15:0]), 128'hAA08);

    // R8: unbuffered store behind two entries
    mem_ready = 0; base = wcnt;
    push(32'h3000, 16'h00FF, 8'h01, 1'b1, 1'b0);
    push(32'h3010, 16'h00FF, 8'h02, 1'b1, 1'b0);
    @(negedge clk);
    st_valid = 1; st_addr = 32'h3020; st_be = 16'hFFFF; st_data = {16{8'h5A}}; st_coal = 0; st_sync = 1;
    repeat (2) @(negedge clk);
    chk(!st_ready, "R8 sync waits", 128'(st_ready), 0);
    mem_ready = 1;
    for (int i = 0; i < 10 && !st_ready; i++) @(negedge clk);
    chk(st_ready && mem_valid && mem_addr == 32'h3020, "R8 sync on port", 128'(mem_addr), 128'h3020);
    chk(wcnt - base == 2, "R8 older first", 128'(wcnt - base), 2);
    @(negedge clk);
    st_valid = 0; st_sync = 0;
    chk(wcnt - base == 3 && w_addr[base+2] == 32'h3020, "R8 sync written",
        128'(w_addr[base+2]), 128'h3020);

    // R9: drain behind three entries
    mem_ready = 0; base = wcnt;
    for (int k = 0; k < 3; k++) push(32'h4000 + 32'(16*k), 16'h0001, 8'h09, 1'b0, 1'b0);
    @(negedge clk);
    drain_req = 1; st_valid = 1; st_addr = 32'h5000; st_be = 16'h0001; st_coal = 0;
    @(negedge clk);
    chk(!st_ready, "R9 stores blocked", 128'(st_ready), 0);
    chk(!drain_done, "R9 not done", 128'(drain_done), 0);
    mem_ready = 1;
    for (int i = 0; i < 10 && !drain_done; i++) @(negedge clk);
    chk(drain_done && wcnt - base == 3, "R9 drained", 128'(wcnt - base), 3);
    chk(!st_ready, "R9 blocked while done", 128'(st_ready), 0);
    drain_req = 0;
    #1;
    chk(st_ready, "R9 released", 128'(st_ready), 1);
    @(negedge clk);
    st_valid = 0;
    wait_idle();

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule